// File: doc/BRIEF.md
# Two-Tone FSK Transmit Framer

This block is the transmit side of a half-duplex fast frequency-shift keyed data link. A host hands it one byte at a time through a single holding buffer. The block turns each byte into a serial bit stream, most significant bit first, at a bit period of `BIT_DIV` master-clock cycles. The default of 3360 gives 1200 bit/s from a 4.032 MHz clock.

When checksum mode is on, the block inserts two check bytes after every group of six data bytes. When it is off, the bytes go out back to back. Once the host stops supplying bytes, one trailing hang bit is sent and the block reports idle.

Each transmitted bit steers a phase accumulator. A one advances the phase by one full tone cycle per bit period, and a zero by one and a half cycles. The output phase code is continuous across bit boundaries and can feed a sine lookup and DAC downstream.

Top module: `ffsk_tx_framer`

## Requirements
- R1: `bit_strobe` is high for one clock in every `BIT_DIV` clocks. Its first pulse comes `BIT_DIV` clocks after reset is released. The serial line changes only on the clock edge that samples a strobe.
- R2: Data bytes are sent most significant bit first on `tx_bit`. Each bit lasts exactly one bit period.
- R3: With `ck_enable` high, a 16-bit check word follows every sixth data byte of a group. The word is sent upper byte first and MSB first. Its upper 15 bits are a CRC over the 48 group bits. The CRC starts at zero and takes the data bits MSB first, using generator x^15+x^14+x^13+x^11+x^4+x^2+1 (feedback mask 0x6815). Bit 0 of the word is set so that the 64 group bits hold an even number of ones.
- R4: With `ck_enable` low, loaded bytes are sent back to back with nothing inserted.
- R5: When a byte (or check word) ends and no byte is waiting, one hang bit of value 1 is sent for one bit period. `tx_idle` then rises. The checksum group restarts from zero.
- R6: `tx_ready` is high exactly while the holding buffer is empty. A write with `wr_valid` high is taken only while `tx_ready` is high. A write while it is low has no effect on the sent data.
- R7: While idle, `tx_bit` is 1. A byte written during idle starts on the next bit strobe, and `tx_idle` falls on that strobe.
- R8: `tone_phase` advances every clock while not idle, by `INC_MARK` (65536/`BIT_DIV`, rounded) for a one and by `INC_SPACE` (1.5 times that) for a zero. It holds its value while idle and is reset only by `rst_n`.
- R9: Reset, which is synchronous and active low, sets the outputs as follows: `tx_ready`=1, `tx_idle`=1, `tx_bit`=1, `tone_phase`=0.
- R10: A byte whose write lands in the same clock as the strobe that ends the last queued bit is too late for that strobe. The hang bit is sent first, and the byte starts one strobe after idle is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst_n | input | 1 | synchronous active-low reset |
| ck_enable | input | 1 | insert check word after each six data bytes |
| wr_valid | input | 1 | host write strobe for `wr_data` |
| wr_data | input | 8 | byte to transmit |
| tx_ready | output | 1 | holding buffer empty, a write will be taken |
| tx_idle | output | 1 | nothing being sent, hang bit finished |
| tx_bit | output | 1 | current serial bit |
| bit_strobe | output | 1 | one-clock pulse marking each bit boundary |
| tone_phase | output | 16 | phase accumulator code for the tone generator |

## Verification
Two events can fall in the same clock: the host write that fills the buffer, and the bit strobe that ends the final bit of a byte or check word. The bench provokes this collision on purpose. It watches its own model and raises `wr_valid` so that the write lands exactly on that last strobe. It then checks that the framer sends the hang bit and goes idle before the late byte starts. A write held while the buffer is full is used to show that the waiting byte is not overwritten. The behavioural model is compared against every output on every clock.

// File: rtl/ffsk_tx_pkg.sv
// Shared types and the check-word arithmetic for the FSK transmit framer.
// Assumes bytes are 8 bits wide and the CRC register is 15 bits wide.
package ffsk_tx_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 15;
    localparam logic [CRC_W-1:0] CRC_MASK = 15'h6815;

    typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_HANG} tx_state_t;
    typedef enum logic [1:0] {K_DATA, K_CKHI, K_CKLO} unit_kind_t;

    // Advance the CRC by one byte, MSB first, with feedback from the top bit.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c_in,
                                                  input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] c;
        logic fb;
        c = c_in;
        for (int i = BYTE_W - 1; i >= 0; i--) begin
            fb = d[i] ^ c[CRC_W-1];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ CRC_MASK;
        end
        return c;
    endfunction

endpackage

// File: rtl/ffsk_bit_timer.sv
// Bit-period divider: a free-running counter that pulses `tick` for one
// clock every BIT_DIV clocks. Assumes BIT_DIV >= 2.
module ffsk_bit_timer #(
    parameter int BIT_DIV = 3360
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(BIT_DIV);
    localparam logic [CW-1:0] LAST = CW'(BIT_DIV - 1);

    logic [CW-1:0] cnt;

    // Count clocks within the bit period and wrap at the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    generate
        if (BIT_DIV > 1) begin : g_strobe_chk
            p_strobe_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/ffsk_byte_framer.sv
// Byte framer: a one-byte holding buffer, the MSB-first serializer, check
// word insertion after each group of GROUP data bytes, and the hang bit.
// Assumes ck_enable is held steady while a transmission is in progress.
module ffsk_byte_framer
    import ffsk_tx_pkg::*;
#(
    parameter int GROUP = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ck_enable,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tx_ready,
    output logic              tx_idle,
    output logic              tx_bit
);
    localparam int GW = $clog2(GROUP + 1);
    localparam int IW = $clog2(BYTE_W);
    localparam logic [IW-1:0] LAST_BIT = IW'(BYTE_W - 1);
    localparam logic [GW-1:0] LAST_GRP = GW'(GROUP - 1);

    tx_state_t          state;
    unit_kind_t         kind;
    logic               buf_full;
    logic [BYTE_W-1:0]  buf_data;
    logic [BYTE_W-1:0]  cur;
    logic [BYTE_W-1:0]  ck_lo;
    logic [IW-1:0]      idx;
    logic [GW-1:0]      gcnt;
    logic [CRC_W-1:0]   crc;
    logic               par;

    logic [CRC_W-1:0]   crc_next;
    logic               par_next;
    logic [2*BYTE_W-1:0] ck_word;
    logic               close_grp;

    // Fold the byte now ending into the group CRC and the running parity.
    always_comb begin
        crc_next  = crc_byte(crc, cur);
        par_next  = par ^ (^cur);
        ck_word   = {crc_next, par_next ^ (^crc_next)};
        close_grp = ck_enable && (gcnt == LAST_GRP);
    end

    // Buffer intake, then bit sequencing at each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= K_DATA;
            buf_full <= 1'b0;
            buf_data <= '0;
            cur      <= '0;
            ck_lo    <= '0;
            idx      <= '0;
            gcnt     <= '0;
            crc      <= '0;
            par      <= 1'b0;
        end else begin
            if (wr_valid && !buf_full) begin
                buf_full <= 1'b1;
                buf_data <= wr_data;
            end
            if (tick) begin
                case (state)
                    ST_IDLE: if (buf_full) begin
                        cur      <= buf_data;
                        kind     <= K_DATA;
                        idx      <= '0;
                        buf_full <= 1'b0;
                        state    <= ST_SEND;
                    end
                    ST_SEND: if (idx != LAST_BIT) begin
                        idx <= idx + 1'b1;
                    end else begin
                        idx <= '0;
                        if (kind == K_DATA && close_grp) begin
                            cur  <= ck_word[2*BYTE_W-1:BYTE_W];
                            ck_lo <= ck_word[BYTE_W-1:0];
                            kind <= K_CKHI;
                            gcnt <= '0;
                            crc  <= '0;
                            par  <= 1'b0;
                        end else if (kind == K_CKHI) begin
                            cur  <= ck_lo;
                            kind <= K_CKLO;
                        end else begin
                            if (kind == K_DATA && ck_enable) begin
                                gcnt <= gcnt + 1'b1;
                                crc  <= crc_next;
                                par  <= par_next;
                            end else if (kind == K_DATA) begin
                                gcnt <= '0;
                                crc  <= '0;
                                par  <= 1'b0;
                            end
                            if (buf_full) begin
                                cur      <= buf_data;
                                kind     <= K_DATA;
                                buf_full <= 1'b0;
                            end else begin
                                state <= ST_HANG;
                                gcnt  <= '0;
                                crc   <= '0;
                                par   <= 1'b0;
                            end
                        end
                    end
                    ST_HANG: state <= ST_IDLE;
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign tx_ready = !buf_full;
    assign tx_idle  = (state == ST_IDLE);
    assign tx_bit   = (state == ST_SEND) ? cur[LAST_BIT - idx] : 1'b1;

    p_hold_between_ticks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state) && $stable(idx) && $stable(cur));
    p_hang_one_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HANG && tick) |=> (state == ST_IDLE));
    p_buffer_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !tick) |=> buf_full && $stable(buf_data));
    p_ck_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && kind == K_CKHI && idx == LAST_BIT && tick)
            |=> (state == ST_SEND && kind == K_CKLO));
endmodule

// File: rtl/ffsk_tone_nco.sv
// Tone phase accumulator: adds a per-bit increment every clock while the
// line is active and holds while idle. No reset between bits keeps the
// phase continuous.
module ffsk_tone_nco #(
    parameter int BIT_DIV = 3360,
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic               bit_in,
    output logic [PHASE_W-1:0] phase
);
    localparam longint FULL      = longint'(1) << PHASE_W;
    localparam logic [PHASE_W-1:0] INC_MARK  = PHASE_W'((FULL + BIT_DIV / 2) / BIT_DIV);
    localparam logic [PHASE_W-1:0] INC_SPACE = PHASE_W'((3 * FULL / 2 + BIT_DIV / 2) / BIT_DIV);

    // Step the phase by the tone chosen for the bit on the line.
    always_ff @(posedge clk) begin
        if (!rst_n)   phase <= '0;
        else if (run) phase <= phase + (bit_in ? INC_MARK : INC_SPACE);
    end

    p_phase_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(phase));
endmodule

// File: rtl/ffsk_tx_framer.sv
// Top of the FSK transmit path: bit timer, byte framer and tone NCO.
// Assumes a master clock of BIT_DIV times the bit rate.
module ffsk_tx_framer #(
    parameter int BIT_DIV = 3360,
    parameter int GROUP   = 6,
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ck_enable,
    input  logic               wr_valid,
    input  logic [7:0]         wr_data,
    output logic               tx_ready,
    output logic               tx_idle,
    output logic               tx_bit,
    output logic               bit_strobe,
    output logic [PHASE_W-1:0] tone_phase
);
    logic tick;

    ffsk_bit_timer #(.BIT_DIV(BIT_DIV)) i_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick));

    ffsk_byte_framer #(.GROUP(GROUP)) i_framer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ck_enable(ck_enable),
        .wr_valid(wr_valid), .wr_data(wr_data), .tx_ready(tx_ready),
        .tx_idle(tx_idle), .tx_bit(tx_bit));

    ffsk_tone_nco #(.BIT_DIV(BIT_DIV), .PHASE_W(PHASE_W)) i_nco (
        .clk(clk), .rst_n(rst_n), .run(!tx_idle), .bit_in(tx_bit),
        .phase(tone_phase));

    assign bit_strobe = tick;

    p_idle_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_idle && !tx_ready && !bit_strobe) |=> tx_idle);
endmodule

// File: tb/test_ffsk_tx_framer.sv
module test_ffsk_tx_framer;
    localparam int DIV = 16;
    localparam int INC1 = 65536 / DIV;
    localparam int INC0 = 98304 / DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ck_enable = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tx_ready, tx_idle, tx_bit, bit_strobe;
    logic [15:0] tone_phase;

    int vectors = 0;
    int errors  = 0;
    int cyc     = 0;
    bit started = 0;
    bit done    = 0;

    ffsk_tx_framer #(.BIT_DIV(DIV)) i_ffsk_tx_framer (
        .clk(clk), .rst_n(rst_n), .ck_enable(ck_enable), .wr_valid(wr_valid),
        .wr_data(wr_data), .tx_ready(tx_ready), .tx_idle(tx_idle),
        .tx_bit(tx_bit), .bit_strobe(bit_strobe), .tone_phase(tone_phase));

    always #5 clk = ~clk;

    // Behavioural reference: queue of bits still owed on the line.
    int m_cnt = 0, m_mode = 0, m_phase = 0;  // mode 0 idle, 1 run, 2 hang
    bit m_full = 0, m_bit = 1, m_tick = 0;
    int m_buf = 0;
    bit bq[$];
    int grp[$];

    function automatic void push_byte(int b);
        int c, ones, w;
        for (int i = 7; i >= 0; i--) bq.push_back(((b >> i) & 1) != 0);
        if (!ck_enable) begin grp.delete(); return; end
        grp.push_back(b);
        if (grp.size() < 6) return;
        c = 0; ones = 0;
        foreach (grp[k]) begin
            for (int i = 7; i >= 0; i--) begin
                int fb;
                fb = ((grp[k] >> i) & 1) ^ ((c >> 14) & 1);
                ones += (grp[k] >> i) & 1;
                c = (c << 1) & 'h7fff;
                if (fb != 0) c = c ^ 'h6815;
            end
        end
        for (int i = 0; i < 15; i++) ones += (c >> i) & 1;
        w = c * 2 + (ones % 2);
        for (int i = 15; i >= 0; i--) bq.push_back(((w >> i) & 1) != 0);
        grp.delete();
    endfunction

    always @(posedge clk) begin
        bit old_full, tk;
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_mode = 0; m_phase = 0; m_full = 0; m_bit = 1;
            bq.delete(); grp.delete(); started = 1;
        end else begin
            old_full = m_full;
            tk = (m_cnt == DIV - 1);
            m_cnt = tk ? 0 : m_cnt + 1;
            if (m_mode != 0) m_phase = (m_phase + (m_bit ? INC1 : INC0)) & 'hffff;
            if (tk) begin
                case (m_mode)
                    0: if (old_full) begin push_byte(m_buf); m_full = 0; m_mode = 1; end
                    1: begin
                        void'(bq.pop_front());
                        if (bq.size() == 0) begin
                            if (old_full) begin push_byte(m_buf); m_full = 0; end
                            else begin m_mode = 2; grp.delete(); end
                        end
                    end
                    default: m_mode = 0;
                endcase
            end
            if (wr_valid && !old_full) begin m_full = 1; m_buf = wr_data; end
            m_bit = (m_mode == 1) ? bq[0] : 1'b1;
        end
        m_tick = (m_cnt == DIV - 1);
    end

    // Compare every output against the model away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            vectors++;
            if (tx_ready !== !m_full) begin
                errors++; $display("FAIL R6 tx_ready act=%0b exp=%0b", tx_ready, !m_full); end
            if (tx_idle !== (m_mode == 0)) begin
                errors++; $display("FAIL R5/R7 tx_idle act=%0b exp=%0b", tx_idle, m_mode == 0); end
            if (tx_bit !== m_bit) begin
                errors++; $display("FAIL R2/R3/R4 tx_bit act=%0b exp=%0b t=%0t", tx_bit, m_bit, $time); end
            if (bit_strobe !== m_tick) begin
                errors++; $display("FAIL R1 bit_strobe act=%0b exp=%0b", bit_strobe, m_tick); end
            if (int'(tone_phase) !== m_phase) begin
                errors++; $display("FAIL R8 tone_phase act=%0h exp=%0h", tone_phase, m_phase); end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin errors++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        wr_valid = 1'b1; wr_data = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (!(tx_idle && tx_ready)) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (cyc == 100000 && !done) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset values
        check(tx_ready && tx_idle && tx_bit && tone_phase == 0, "R9 reset outputs",
              {tx_ready, tx_idle, tx_bit}, 3'b111);
        rst_n = 1'b1;

        // R3: two full checksum groups back to back
        ck_enable = 1'b1;
        for (int i = 0; i < 12; i++) put(8'(8'h11 * i + 8'h5A));
        wait_idle();
        check(tx_idle === 1'b1, "R5 idle after groups", tx_idle, 1);

        // R4: checksum off, back to back
        ck_enable = 1'b0;
        for (int i = 0; i < 7; i++) put(8'(8'hC3 ^ (i * 37)));
        wait_idle();

        // R5: underrun mid-group restarts the group, then a full group
        ck_enable = 1'b1;
        for (int i = 0; i < 3; i++) put(8'(8'hF0 + i));
        wait_idle();
        for (int i = 0; i < 6; i++) put(8'(i == 0 ? 8'h00 : 8'hFF));
        wait_idle();

        // R6: write attempt while buffer full is ignored
        put(8'hA5);
        put(8'h3C);
        @(negedge clk);
        check(tx_ready === 1'b0, "R6 buffer full", tx_ready, 0);
        wr_valid = 1'b1; wr_data = 8'hEE;
        repeat (5) @(negedge clk);
        wr_valid = 1'b0;
        wait_idle();

        // R10: write landing on the strobe that ends the final bit
        ck_enable = 1'b0;
        put(8'h81);
        @(negedge clk);
        while (!(m_tick && m_mode == 1 && bq.size() == 1 && !m_full)) @(negedge clk);
        wr_valid = 1'b1; wr_data = 8'h7E;
        @(negedge clk);
        wr_valid = 1'b0;
        check(tx_ready === 1'b0 && tx_idle === 1'b0 && tx_bit === 1'b1,
              "R10 hang before late byte", {tx_ready, tx_idle, tx_bit}, 3'b001);
        while (!bit_strobe) @(negedge clk);
        @(negedge clk);
        check(tx_idle === 1'b1 && tx_ready === 1'b0, "R10 idle with byte held",
              {tx_idle, tx_ready}, 2'b10);
        // R7: held byte starts on next strobe
        while (!bit_strobe) @(negedge clk);
        @(negedge clk);
        check(tx_idle === 1'b0 && tx_bit === 1'b0, "R7 start on strobe",
              {tx_idle, tx_bit}, 2'b00);
        wait_idle();
        // R8: phase frozen while idle
        begin
            logic [15:0] ph;
            ph = tone_phase;
            repeat (40) @(negedge clk);
            check(tone_phase === ph, "R8 phase held idle", tone_phase, ph);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule